// File: doc/BRIEF.md
# Branch Condition Evaluation Unit

This block decides whether a conditional branch is taken. In a first step, while a capture strobe is high, it evaluates a three-bit condition code, taken from the three least significant bits of the instruction word, against a 32-bit value present on the data bus. It stores the outcome in a one-bit internal flag. Software cannot read this flag.

In a later branch step, the target value is placed on the bus without any condition. The block asserts a program-counter load enable only when the stored flag is set. The new program-counter value is passed through from a separate input. Fetch, bus driving and the register file are outside this block.

Top module: `branch_cond_unit`

## Requirements
- R1: Reset clears the decision flag to 0, so with the branch strobe high after reset `pc_load` is 0.
- R2: Condition code 0 (instr bits [2:0] = 3'd0) evaluates as not taken, and code 1 evaluates as taken, whatever the bus value.
- R3: Code 2 is taken when the bus value is all zeros. Code 3 is taken when the bus value is not all zeros.
- R4: Code 4 is taken when bus bit 31 is 0. Code 5 is taken when bus bit 31 is 1.
- R5: Codes 6 and 7 evaluate as not taken.
- R6: The flag takes the evaluated result on a rising clock edge with `capture` high, and holds its value on every edge with `capture` low.
- R7: `pc_load` is combinational and equals the flag AND `branch_step`. It is 0 whenever `branch_step` is low.
- R8: `pc_next` always equals `target_in`, with or without the flag set.
- R9: When `capture` and `branch_step` are both high in the same cycle, `pc_load` reflects the flag from before that edge. The new result is visible only after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Instruction word; bits [2:0] hold the condition code |
| bus_val | input | 32 | Value on the data bus being tested |
| capture | input | 1 | Evaluate-and-store step strobe |
| branch_step | input | 1 | Branch step strobe |
| target_in | input | 32 | Candidate new program-counter value |
| pc_load | output | 1 | Program-counter load enable |
| pc_next | output | 32 | New program-counter value (pass-through) |

## Verification
Capture and the branch step can fall in the same cycle. In that cycle the load enable must still follow the previously stored decision while a new decision is being written. The bench raises both strobes together with a condition whose result is opposite to the stored flag. It then checks that the output before the edge follows the old flag and that the output after the edge follows the new one. A behavioural reference flag in the bench is compared against the outputs on every cycle.

// File: rtl/branch_cond_unit.sv
module branch_cond_unit #(
  parameter int W = 32,
  parameter int CW = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] instr,
  input  logic [W-1:0] bus_val,
  input  logic         capture,
  input  logic         branch_step,
  input  logic [W-1:0] target_in,
  output logic         pc_load,
  output logic [W-1:0] pc_next
);
  localparam int SB = W - 1;

  logic [CW-1:0] code;
  logic is_zero, is_neg, cond_ok, flag_q;

  assign code    = instr[CW-1:0];
  assign is_zero = ~|bus_val;
  assign is_neg  = bus_val[SB];

  always_comb begin
    case (code)
      3'd0:    cond_ok = 1'b0;
      3'd1:    cond_ok = 1'b1;
      3'd2:    cond_ok = is_zero;
      3'd3:    cond_ok = ~is_zero;
      3'd4:    cond_ok = ~is_neg;
      3'd5:    cond_ok = is_neg;
      default: cond_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (capture) flag_q <= cond_ok;
  end

  assign pc_load = flag_q & branch_step;
  assign pc_next = target_in;

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> !flag_q);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(flag_q));
  a_r2_never: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && instr[2:0] == 3'd0) |=> !flag_q);
  a_r2_always: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && instr[2:0] == 3'd1) |=> flag_q);
  a_r3_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && instr[2:0] == 3'd2) |=> (flag_q == ($past(bus_val) == '0)));
  a_r4_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && instr[2:0] == 3'd5) |=> (flag_q == $past(bus_val[SB])));
  a_r5_unused: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && instr[2:0] >= 3'd6) |=> !flag_q);
  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !branch_step |-> !pc_load);
endmodule

// File: tb/tb_branch_cond_unit.sv
module tb_branch_cond_unit;
  logic clk = 0, rst_n = 0;
  logic [31:0] instr = 0, bus_val = 0, target_in = 0;
  logic capture = 0, branch_step = 0;
  logic pc_load;
  logic [31:0] pc_next;
  int compared = 0, mismatched = 0;
  bit ref_flag = 0;

  always #10 clk = ~clk;

  branch_cond_unit dut (.clk(clk), .rst_n(rst_n), .instr(instr), .bus_val(bus_val),
    .capture(capture), .branch_step(branch_step), .target_in(target_in),
    .pc_load(pc_load), .pc_next(pc_next));

  function automatic bit model(input int c, input logic [31:0] v);
    case (c)
      1: return 1;
      2: return v == 0;
      3: return v != 0;
      4: return v[31] == 0;
      5: return v[31] == 1;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // compare continuously at mid-cycle
  always @(negedge clk) if (rst_n) begin
    chk("R7", {31'b0, pc_load}, {31'b0, ref_flag & branch_step});
    chk("R8", pc_next, target_in);
  end

  always @(posedge clk) begin
    if (!rst_n) ref_flag <= 0;
    else if (capture) ref_flag <= model(int'(instr[2:0]), bus_val);
  end

  task automatic step(input int c, input logic [31:0] v, input bit cap, input bit br,
                      input logic [31:0] tg);
    @(posedge clk); #2;
    instr = {$urandom, 3'b0} | 32'(c); bus_val = v; capture = cap;
    branch_step = br; target_in = tg;
  endtask

  task automatic cap_then_check(input string req, input int c, input logic [31:0] v,
                                input bit exp);
    step(c, v, 1, 0, 32'h100);
    step(7, 32'hFFFF_FFFF, 0, 1, 32'h200 + c);
    #5 chk(req, {31'b0, pc_load}, {31'b0, exp});
  endtask

  initial begin
    fork begin #1_000_000; mismatched++; $display("FAIL watchdog"); end join_none
    branch_step = 1;
    repeat (2) @(posedge clk);
    #5 chk("R1", {31'b0, pc_load}, 0);
    rst_n = 1;
    @(posedge clk); #5 chk("R1", {31'b0, pc_load}, 0);
    cap_then_check("R2", 0, 32'h0, 0);
    cap_then_check("R2", 1, 32'h8000_0000, 1);
    cap_then_check("R3", 2, 32'h0, 1);
    cap_then_check("R3", 2, 32'h0000_0001, 0);
    cap_then_check("R3", 3, 32'h0, 0);
    cap_then_check("R3", 3, 32'h0100_0000, 1);
    cap_then_check("R4", 4, 32'h7FFF_FFFF, 1);
    cap_then_check("R4", 4, 32'h8000_0000, 0);
    cap_then_check("R4", 5, 32'h8000_0000, 1);
    cap_then_check("R4", 5, 32'h0, 0);
    cap_then_check("R5", 6, 32'h0, 0);
    cap_then_check("R5", 7, 32'h8000_0000, 0);
    // R6: set flag, then hold with capture low while inputs would clear it
    step(1, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 32'hABCD);
    #5 chk("R6", {31'b0, pc_load}, 1);
    step(0, 0, 0, 0, 32'h1234);
    #5 chk("R7", {31'b0, pc_load}, 0);
    chk("R8", pc_next, 32'h1234);
    // R9: both strobes together, old flag=1, new result 0
    step(0, 0, 1, 1, 32'h55);
    #5 chk("R9", {31'b0, pc_load}, 1);
    @(posedge clk); #5 chk("R9", {31'b0, pc_load}, 0);
    // R9 reverse: old 0, new 1
    step(1, 0, 1, 1, 32'h66);
    #5 chk("R9", {31'b0, pc_load}, 0);
    @(posedge clk); #5 chk("R9", {31'b0, pc_load}, 1);
    for (int i = 0; i < 200; i++)
      step($urandom_range(0, 7), ($urandom & 1) ? 32'h0 : $urandom,
           $urandom & 1, $urandom & 1, $urandom);
    step(0, 0, 0, 0, 0);
    @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule